// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The controller gathers level-sensitive requests from up to 32 on-chip peripheral lines and drives a single registered request line, together with a 3-bit request level, toward the host CPU. Software programs a configuration word, a per-source enable mask and an end-of-interrupt register through a small register port. It can also read a pending register that mirrors the registered input levels. Line 0 is reserved: its input is ignored, and number 0 is the error vector.

To take an interrupt, the host writes 1 to bit 0 of the vector register. The controller then selects the winning eligible source, records it, and sets that source's in-service bit. The next read of the vector register returns the source number in bits [15:11]. The host services the source, masks it while its level is still asserted, and finally writes a 1 to its in-service bit. An acknowledge that finds no eligible source returns the error vector 0 and sets no in-service bit. This covers the case where a mask write races a request.

Four priority slots, numbered `SLOT_BASE` to `SLOT_BASE+3`, are fed through a programmable remap of the four serial-channel input lines. Software can therefore reorder those channels without touching the rest of the priority chain. The acknowledge handshake is a two-state machine. `S_IDLE` means no vector is held. The ACK_WRITE transition moves `S_IDLE` to `S_ACKED`; in `S_ACKED`, ACK_WRITE stays in `S_ACKED` and latches a fresh vector. The VECTOR_READ transition moves `S_ACKED` to `S_IDLE`.

Top module: `vpic_top`

## Requirements
- R1: Bit n of the mask register (address 2, read/write, reset 0) enables source n; a pending source whose mask bit is 0 never raises `cpu_irq` and is never selected by an acknowledge.
- R2: Writing the in-service register (address 3) clears every bit written as 1; bits written as 0 keep their value. Reading address 3 returns the in-service bits.
- R3: Writing a 1 to bit 0 of address 4 acknowledges. The first read of address 4 after it returns the latched vector in bits [15:11], with all other bits 0. A read of address 4 with no acknowledge since the previous read returns 0.
- R4: Among eligible sources, the higher source number wins. Input line 0 is ignored, so pending bit 0 always reads 0.
- R5: The configuration field at bits [12:8] names a source promoted above all others. Its reset value 0 promotes nothing.
- R6: While in-service bits are set, a source is eligible only if its priority is strictly above that of every in-service source. This holds for the request line and for the acknowledge alike.
- R7: An acknowledge with no eligible source latches vector 0 and leaves the in-service register unchanged.
- R8: `cpu_irq` is registered. It equals the global enable (configuration bit 7) ANDed with "an eligible source exists", as seen one clock earlier. A level change on `irq_in` reaches `cpu_irq` at the second rising edge.
- R9: Configuration bits [15:13] drive `cpu_level` directly after the write.
- R10: Configuration bits [17+2j:16+2j] select which input line `SLOT_BASE+k` feeds priority slot `SLOT_BASE+j`. These bits reset to the identity order (configuration reset value 0x00E40000 for four slots).
- R11: The pending register (address 1, read-only) returns the remapped input levels, registered once.
- R12: A successful acknowledge sets the in-service bit of the winning source at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive peripheral request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the vector handshake) |
| reg_addr | input | 3 | Register address: 0 config, 1 pending, 2 mask, 3 in-service, 4 vector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| cpu_irq | output | 1 | Registered request line to the CPU |
| cpu_level | output | 3 | Request level presented to the CPU |

## Verification
An input level is captured into the pending register at the first rising edge. The request line responds at the second edge. A mask, configuration or end-of-interrupt write changes the request line one edge after the write edge. An acknowledge sets in-service state and the vector at its own write edge, so the read data is valid in the next cycle. The bench drives every stimulus on the falling edge and samples at the falling edge that follows the edge at which the result is due. Before each dependent check it waits exactly those one or two edges, and it checks both sides of the two-edge request latency explicitly. A sweep acknowledges and retires every source 1 to 31 in turn; directed cases then cover priority order, promotion, nesting, masking races, slot remapping and the enable.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam logic [2:0] ADDR_CFG  = 3'd0;
    localparam logic [2:0] ADDR_PEND = 3'd1;
    localparam logic [2:0] ADDR_MASK = 3'd2;
    localparam logic [2:0] ADDR_INSV = 3'd3;
    localparam logic [2:0] ADDR_VEC  = 3'd4;

    localparam int VEC_LSB   = 11;
    localparam int LVL_LSB   = 13;
    localparam int HP_LSB    = 8;
    localparam int EN_BIT    = 7;
    localparam int SLOT_LSB  = 16;
    localparam int NSLOT     = 4;

    typedef enum logic {
        S_IDLE,
        S_ACKED
    } ack_state_e;

endpackage

// File: rtl/vpic_remap.sv
module vpic_remap #(
    parameter int NSRC      = 32,
    parameter int SLOT_BASE = 28,
    parameter int NSLOT     = 4,
    localparam int SEL_W    = $clog2(NSLOT)
) (
    input  logic [NSRC-1:0]        irq_i,
    input  logic [NSLOT*SEL_W-1:0] sel_i,
    output logic [NSRC-1:0]        req_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_line
        if (i == 0) begin : g_reserved
            assign req_o[i] = 1'b0;
        end else if (i >= SLOT_BASE && i < SLOT_BASE + NSLOT) begin : g_slot
            logic [SEL_W-1:0] pick;
            assign pick     = sel_i[(i-SLOT_BASE)*SEL_W +: SEL_W];
            assign req_o[i] = irq_i[SLOT_BASE + int'(pick)];
        end else begin : g_plain
            assign req_o[i] = irq_i[i];
        end
    end

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
    parameter int NSRC  = 32,
    localparam int VEC_W = $clog2(NSRC),
    localparam int KEY_W = VEC_W + 1
) (
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  mask_i,
    input  logic [NSRC-1:0]  isr_i,
    input  logic [VEC_W-1:0] hp_i,
    output logic             elig_o,
    output logic [VEC_W-1:0] win_o
);

    logic [NSRC-1:0]  cand;
    logic             win_ok, isv_ok;
    logic [KEY_W-1:0] win_key, isv_key;

    function automatic logic [KEY_W-1:0] key_of(input logic [VEC_W-1:0] id,
                                                 input logic [VEC_W-1:0] hp);
        return {id == hp, id};
    endfunction

    assign cand = pend_i & mask_i;

    always_comb begin
        win_ok  = 1'b0;
        win_o   = '0;
        win_key = '0;
        isv_ok  = 1'b0;
        isv_key = '0;
        for (int v = 1; v < NSRC; v++) begin
            if (cand[v] && (!win_ok || key_of(VEC_W'(v), hp_i) > win_key)) begin
                win_ok  = 1'b1;
                win_o   = VEC_W'(v);
                win_key = key_of(VEC_W'(v), hp_i);
            end
            if (isr_i[v] && (!isv_ok || key_of(VEC_W'(v), hp_i) > isv_key)) begin
                isv_ok  = 1'b1;
                isv_key = key_of(VEC_W'(v), hp_i);
            end
        end
        elig_o = win_ok && (!isv_ok || win_key > isv_key);
    end

endmodule

// File: rtl/vpic_ack.sv
module vpic_ack
    import vpic_pkg::*;
#(
    parameter int NSRC  = 32,
    localparam int VEC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             vrd_i,
    input  logic             elig_i,
    input  logic [VEC_W-1:0] win_i,
    output ack_state_e       state_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NSRC-1:0]  isr_set_o
);

    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ack_i) state_d = S_ACKED;
            S_ACKED: begin
                if (ack_i)      state_d = S_ACKED;
                else if (vrd_i) state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ack_i) vec_q <= elig_i ? win_i : '0;
        end
    end

    always_comb begin
        state_o   = state_q;
        vec_o     = (state_q == S_ACKED) ? vec_q : '0;
        isr_set_o = '0;
        if (ack_i && elig_i) isr_set_o[win_i] = 1'b1;
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int SLOT_BASE = 28,
    localparam int VEC_W    = $clog2(NSRC),
    localparam int SEL_W    = $clog2(NSLOT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cpu_irq,
    output logic [2:0]  cpu_level
);

    logic [NSRC-1:0]        pend_q, mask_q, isr_q, req_map, isr_set;
    logic [2:0]             lvl_q;
    logic [VEC_W-1:0]       hp_q, win, vec;
    logic                   cfg_en_q, elig;
    logic [NSLOT*SEL_W-1:0] slot_q;
    ack_state_e             state_q;

    logic wr_cfg, wr_mask, wr_insv, ack, vrd;
    assign wr_cfg  = reg_wr && reg_addr == ADDR_CFG;
    assign wr_mask = reg_wr && reg_addr == ADDR_MASK;
    assign wr_insv = reg_wr && reg_addr == ADDR_INSV;
    assign ack     = reg_wr && reg_addr == ADDR_VEC && reg_wdata[0];
    assign vrd     = reg_rd && reg_addr == ADDR_VEC;

    vpic_remap #(.NSRC(NSRC), .SLOT_BASE(SLOT_BASE), .NSLOT(NSLOT)) u_remap (
        .irq_i (irq_in[NSRC-1:0]),
        .sel_i (slot_q),
        .req_o (req_map)
    );

    vpic_arb #(.NSRC(NSRC)) u_arb (
        .pend_i (pend_q),
        .mask_i (mask_q),
        .isr_i  (isr_q),
        .hp_i   (hp_q),
        .elig_o (elig),
        .win_o  (win)
    );

    vpic_ack #(.NSRC(NSRC)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_i     (ack),
        .vrd_i     (vrd),
        .elig_i    (elig),
        .win_i     (win),
        .state_o   (state_q),
        .vec_o     (vec),
        .isr_set_o (isr_set)
    );

    function automatic logic [NSLOT*SEL_W-1:0] slot_identity();
        logic [NSLOT*SEL_W-1:0] r;
        for (int j = 0; j < NSLOT; j++) r[j*SEL_W +: SEL_W] = SEL_W'(j);
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            mask_q   <= '0;
            isr_q    <= '0;
            lvl_q    <= '0;
            hp_q     <= '0;
            cfg_en_q <= 1'b0;
            slot_q   <= slot_identity();
            cpu_irq  <= 1'b0;
        end else begin
            pend_q  <= req_map;
            cpu_irq <= cfg_en_q && elig;
            isr_q   <= (isr_q & ~(wr_insv ? reg_wdata[NSRC-1:0] : '0)) | isr_set;
            if (wr_mask) mask_q <= reg_wdata[NSRC-1:0];
            if (wr_cfg) begin
                lvl_q    <= reg_wdata[LVL_LSB +: 3];
                hp_q     <= reg_wdata[HP_LSB +: VEC_W];
                cfg_en_q <= reg_wdata[EN_BIT];
                slot_q   <= reg_wdata[SLOT_LSB +: NSLOT*SEL_W];
            end
        end
    end

    assign cpu_level = lvl_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[LVL_LSB +: 3]               = lvl_q;
                reg_rdata[HP_LSB +: VEC_W]            = hp_q;
                reg_rdata[EN_BIT]                     = cfg_en_q;
                reg_rdata[SLOT_LSB +: NSLOT*SEL_W]    = slot_q;
            end
            ADDR_PEND: reg_rdata[NSRC-1:0] = pend_q;
            ADDR_MASK: reg_rdata[NSRC-1:0] = mask_q;
            ADDR_INSV: reg_rdata[NSRC-1:0] = isr_q;
            ADDR_VEC:  reg_rdata[VEC_LSB +: VEC_W] = vec;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
    import vpic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [2:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [31:0]     reg_rdata,
    input logic            cpu_irq,
    input logic            cfg_en_q,
    input logic [NSRC-1:0] pend_q,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] isr_q,
    input ack_state_e      state_q
);

    p_en_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_q |=> !cpu_irq);

    p_rise_needs_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past((pend_q & mask_q) != '0));

    p_eoi_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_INSV) |=> ((isr_q & $past(reg_wdata[NSRC-1:0])) == '0));

    p_err_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_VEC && reg_wdata[0] && (pend_q & mask_q) == '0)
        |=> $stable(isr_q));

    p_idle_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_VEC && state_q == S_IDLE) |-> reg_rdata == '0);

    p_read_ends_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == ADDR_VEC && state_q == S_ACKED) |=> state_q == S_IDLE);

endmodule

bind vpic_top vpic_checker #(.NSRC(NSRC)) u_chk (.*);

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;
    logic [2:0]  cpu_level;

    int checks = 0, errors = 0;
    bit done = 0;

    localparam logic [31:0] CFG_BASE = 32'h00E4_0080; // identity slots, enable

    always #10 clk = ~clk;

    vpic_top u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack_vec(output logic [31:0] v);
        wr(3'd4, 32'h1);
        rd(3'd4, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        check("R8 reset cpu_irq", {31'b0, cpu_irq}, 32'h0);
        rd(3'd2, d); check("R1 reset mask", d, 32'h0);
        rd(3'd0, d); check("R10 reset config", d, 32'h00E4_0000);
        rd(3'd4, d); check("R3 read without ack", d, 32'h0);

        wr(3'd0, CFG_BASE);
        wr(3'd2, 32'hFFFF_FFFF);

        // sweep every source
        for (int s = 1; s < 32; s++) begin
            irq_in = 32'(1) << s;
            idle(2);
            check("R8 sweep request", {31'b0, cpu_irq}, 32'h1);
            rd(3'd1, d); check("R11 sweep pending", d, 32'(1) << s);
            ack_vec(d); check("R3 sweep vector", d, 32'(s) << 11);
            rd(3'd3, d); check("R12 sweep in-service", d, 32'(1) << s);
            check("R6 self not higher", {31'b0, cpu_irq}, 32'h0);
            wr(3'd3, 32'(1) << s);
            idle(1);
            check("R2 eoi rearms", {31'b0, cpu_irq}, 32'h1);
            irq_in = '0;
            idle(2);
        end

        // R4 source 0 ignored, fixed priority
        irq_in = 32'h1; idle(2);
        rd(3'd1, d); check("R4 line 0 pending", d, 32'h0);
        check("R4 line 0 no request", {31'b0, cpu_irq}, 32'h0);
        irq_in = (32'(1) << 4) | (32'(1) << 20); idle(2);
        ack_vec(d); check("R4 higher number wins", d, 32'(20) << 11);
        wr(3'd3, 32'(1) << 20);

        // R5 promotion
        wr(3'd0, CFG_BASE | (32'(4) << 8));
        ack_vec(d); check("R5 promoted source", d, 32'(4) << 11);
        wr(3'd3, 32'(1) << 4);
        wr(3'd0, CFG_BASE);
        irq_in = '0; idle(2);

        // R6 nesting, R7 error vector, R2 partial eoi
        irq_in = 32'(1) << 10; idle(2);
        ack_vec(d); check("R6 first level", d, 32'(10) << 11);
        irq_in = (32'(1) << 10) | (32'(1) << 5); idle(2);
        check("R6 lower blocked", {31'b0, cpu_irq}, 32'h0);
        ack_vec(d); check("R7 no eligible vector", d, 32'h0);
        rd(3'd3, d); check("R7 isr untouched", d, 32'(1) << 10);
        irq_in = irq_in | (32'(1) << 12); idle(2);
        check("R6 higher nests", {31'b0, cpu_irq}, 32'h1);
        ack_vec(d); check("R6 nested vector", d, 32'(12) << 11);
        wr(3'd3, 32'(1) << 12);
        rd(3'd3, d); check("R2 zeros keep bits", d, 32'(1) << 10);
        wr(3'd3, 32'(1) << 10);
        rd(3'd3, d); check("R2 eoi clears", d, 32'h0);
        irq_in = '0; idle(2);

        // R7 race: masked before acknowledge
        irq_in = 32'(1) << 7; idle(2);
        wr(3'd2, 32'h0);
        ack_vec(d); check("R7 race vector", d, 32'h0);
        rd(3'd3, d); check("R7 race isr", d, 32'h0);
        rd(3'd4, d); check("R3 second read zero", d, 32'h0);

        // R1 single mask bit
        wr(3'd2, ~(32'(1) << 7));
        idle(1);
        check("R1 masked no request", {31'b0, cpu_irq}, 32'h0);
        rd(3'd2, d); check("R1 mask readback", d, ~(32'(1) << 7));
        wr(3'd2, 32'hFFFF_FFFF);
        idle(1);
        check("R1 unmasked request", {31'b0, cpu_irq}, 32'h1);
        irq_in = '0; idle(2);

        // R8 latency and enable
        @(negedge clk) irq_in = 32'(1) << 9;
        @(negedge clk);
        check("R8 not yet at edge 1", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R8 at edge 2", {31'b0, cpu_irq}, 32'h1);
        wr(3'd0, CFG_BASE & ~32'h80);
        idle(1);
        check("R8 enable off", {31'b0, cpu_irq}, 32'h0);
        irq_in = '0;

        // R9 level
        wr(3'd0, CFG_BASE | (32'(5) << 13));
        check("R9 level", {29'b0, cpu_level}, 32'h5);

        // R10 remap: slot 28 <- line 31, slot 31 <- line 28
        wr(3'd0, 32'h0027_0080);
        irq_in = 32'(1) << 31; idle(2);
        rd(3'd1, d); check("R10 remap pending", d, 32'(1) << 28);
        ack_vec(d); check("R10 remap vector", d, 32'(28) << 11);
        wr(3'd3, 32'(1) << 28);
        irq_in = '0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule